// File: doc/BRIEF.md
# Dual-Port RAM with Address-Contention Arbiter

This block is a synchronous two-port RAM. The left port (A) and the right port (B) each have an active-low chip enable, a read/write strobe (low means write), an active-low output enable, an address, two active-low byte-lane selects, write data and registered read data. Either port may read or write any word in any cycle. Reads see the contents from before any write made in the same cycle.

When both ports are enabled at the same address, an arbiter grants the word to one port and raises that cycle's contention flag to the other. The port that was already sitting on the address in the previous cycle keeps it. A fresh collision from both sides goes to port A. A write from the flagged port is dropped.

A mode strap lets several devices sit side by side to make a wider word. When the strap is high, the device arbitrates and drives its contention flags out. When it is low, it does no arbitration. Its flag outputs stay low, and flags supplied from a master device block writes instead.

Top module: `dpr_contend_top`

## Requirements
- R1: A port writes when chip enable is low, the read/write strobe is low and at least one lane select is low. The upper select gates data bits [15:8] and the lower select gates bits [7:0]. A lane whose select is high keeps its stored value.
- R2: A port reads when chip enable is low, the strobe is high and output enable is low. The stored word appears on its read data one clock later, with every lane whose select is high forced to zero.
- R3: A port that has chip enable high, or output enable high, in a cycle shows all-zero read data one clock later.
- R4: A contention flag output is high only when the mode strap is high, both chip enables are low and the two addresses are equal.
- R5: When contention starts and exactly one port was enabled at that same address in the previous cycle, that port is granted. The other port's flag rises in the same cycle that contention starts.
- R6: When contention starts and neither port held the address in the previous cycle, port A is granted and port B is flagged. At most one flag is high in any cycle.
- R7: The grant does not change while contention lasts. The flag falls in the same cycle that the addresses differ or either chip enable goes high.
- R8: In master mode, a write from a flagged port leaves the array unchanged.
- R9: With the strap low, both flag outputs stay low and no local arbitration takes place. A high flag input on a port blocks that port's writes.
- R10: When one port writes a word and the other port reads it in the same cycle, the reader receives the contents from before the write.
- R11: During and right after reset, both read data outputs and both flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1: arbitrate locally; 0: take flags as inputs |
| pa_ce_n | input | 1 | Port A chip enable, active low |
| pa_rw_n | input | 1 | Port A strobe, 0 = write, 1 = read |
| pa_oe_n | input | 1 | Port A output enable, active low |
| pa_ub_n | input | 1 | Port A upper lane select, active low |
| pa_lb_n | input | 1 | Port A lower lane select, active low |
| pa_addr | input | ADDR_W | Port A word address |
| pa_wdata | input | 2*LANE_W | Port A write data |
| pa_rdata | output | 2*LANE_W | Port A read data, one cycle latency |
| pa_busy_i | input | 1 | Port A contention flag from a master (slave mode) |
| pa_busy_o | output | 1 | Port A contention flag (master mode) |
| pb_ce_n | input | 1 | Port B chip enable, active low |
| pb_rw_n | input | 1 | Port B strobe, 0 = write, 1 = read |
| pb_oe_n | input | 1 | Port B output enable, active low |
| pb_ub_n | input | 1 | Port B upper lane select, active low |
| pb_lb_n | input | 1 | Port B lower lane select, active low |
| pb_addr | input | ADDR_W | Port B word address |
| pb_wdata | input | 2*LANE_W | Port B write data |
| pb_rdata | output | 2*LANE_W | Port B read data, one cycle latency |
| pb_busy_i | input | 1 | Port B contention flag from a master (slave mode) |
| pb_busy_o | output | 1 | Port B contention flag (master mode) |

## Verification
The contention flags are combinational from the current inputs and the previous cycle's state. The bench therefore checks them one nanosecond after it applies a cycle's inputs, before the next clock edge. Read data is due one edge later. For each cycle, the driver pushes the expected pair, built from a word model taken before that cycle's writes. The monitor pops and compares that pair two nanoseconds after the following rising edge. Whether a write is dropped is shown through a later read of the same word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_on,
  input  logic              a_en,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              a_busy,
  output logic              b_busy
);
  owner_e            owner_q, owner_d;
  logic              a_en_q, b_en_q;
  logic [ADDR_W-1:0] a_addr_q, b_addr_q;
  logic              clash, a_stay, b_stay;

  always_comb begin
    clash  = arb_on & a_en & b_en & (a_addr == b_addr);
    a_stay = a_en_q & (a_addr_q == a_addr);
    b_stay = b_en_q & (b_addr_q == b_addr);
    if (!clash)                   owner_d = OWN_NONE;
    else if (owner_q != OWN_NONE) owner_d = owner_q;
    else if (b_stay && !a_stay)   owner_d = OWN_B;
    else                          owner_d = OWN_A;
    a_busy = (owner_d == OWN_B);
    b_busy = (owner_d == OWN_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      a_en_q  <= 1'b0;
      b_en_q  <= 1'b0;
    end else begin
      owner_q <= owner_d;
      a_en_q  <= a_en;
      b_en_q  <= b_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_addr_q <= '0;
      b_addr_q <= '0;
    end else begin
      if (a_en) a_addr_q <= a_addr;
      if (b_en) b_addr_q <= b_addr;
    end
  end

  AST_ONE_SIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_busy && b_busy)); // R6

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (clash && $past(clash)) |-> ($stable(a_busy) && $stable(b_busy))); // R7
endmodule

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl #(
  parameter int LANES = 2
) (
  input  logic             ce_n,
  input  logic             rw_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             blocked,
  output logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] rd_lane
);
  logic [LANES-1:0] sel;
  logic             wr_go, rd_go;

  always_comb begin
    sel     = ~lane_n;
    wr_go   = !ce_n && !rw_n && !blocked;
    rd_go   = !ce_n && rw_n && !oe_n;
    wr_lane = wr_go ? sel : '0;
    rd_lane = rd_go ? sel : '0;
  end
endmodule

// File: rtl/dpr_lane_bank.sv
module dpr_lane_bank #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANE_W-1:0] a_wd,
  output logic [LANE_W-1:0] a_rd,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANE_W-1:0] b_wd,
  output logic [LANE_W-1:0] b_rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] a_rd_d, b_rd_d;

  always_comb begin
    a_rd_d = a_re ? mem[a_addr] : '0;
    b_rd_d = b_re ? mem[b_addr] : '0;
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wd;
    if (b_we) mem[b_addr] <= b_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rd <= '0;
      b_rd <= '0;
    end else begin
      a_rd <= a_rd_d;
      b_rd <= b_rd_d;
    end
  end
endmodule

// File: rtl/dpr_contend_top.sv
module dpr_contend_top #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                master_mode,
  input  logic                pa_ce_n,
  input  logic                pa_rw_n,
  input  logic                pa_oe_n,
  input  logic                pa_ub_n,
  input  logic                pa_lb_n,
  input  logic [ADDR_W-1:0]   pa_addr,
  input  logic [2*LANE_W-1:0] pa_wdata,
  output logic [2*LANE_W-1:0] pa_rdata,
  input  logic                pa_busy_i,
  output logic                pa_busy_o,
  input  logic                pb_ce_n,
  input  logic                pb_rw_n,
  input  logic                pb_oe_n,
  input  logic                pb_ub_n,
  input  logic                pb_lb_n,
  input  logic [ADDR_W-1:0]   pb_addr,
  input  logic [2*LANE_W-1:0] pb_wdata,
  output logic [2*LANE_W-1:0] pb_rdata,
  input  logic                pb_busy_i,
  output logic                pb_busy_o
);
  localparam int LANES = 2;

  logic             a_busy_loc, b_busy_loc, a_blk, b_blk;
  logic [LANES-1:0] a_wr_lane, a_rd_lane, b_wr_lane, b_rd_lane;

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .arb_on (master_mode),
    .a_en   (!pa_ce_n),
    .b_en   (!pb_ce_n),
    .a_addr (pa_addr),
    .b_addr (pb_addr),
    .a_busy (a_busy_loc),
    .b_busy (b_busy_loc)
  );

  always_comb begin
    a_blk     = master_mode ? a_busy_loc : pa_busy_i;
    b_blk     = master_mode ? b_busy_loc : pb_busy_i;
    pa_busy_o = a_busy_loc;
    pb_busy_o = b_busy_loc;
  end

  dpr_port_ctrl #(.LANES(LANES)) u_ctl_a (
    .ce_n (pa_ce_n), .rw_n (pa_rw_n), .oe_n (pa_oe_n),
    .lane_n ({pa_ub_n, pa_lb_n}), .blocked (a_blk),
    .wr_lane (a_wr_lane), .rd_lane (a_rd_lane)
  );

  dpr_port_ctrl #(.LANES(LANES)) u_ctl_b (
    .ce_n (pb_ce_n), .rw_n (pb_rw_n), .oe_n (pb_oe_n),
    .lane_n ({pb_ub_n, pb_lb_n}), .blocked (b_blk),
    .wr_lane (b_wr_lane), .rd_lane (b_rd_lane)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dpr_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_we   (a_wr_lane[g]),
      .a_re   (a_rd_lane[g]),
      .a_addr (pa_addr),
      .a_wd   (pa_wdata[g*LANE_W +: LANE_W]),
      .a_rd   (pa_rdata[g*LANE_W +: LANE_W]),
      .b_we   (b_wr_lane[g]),
      .b_re   (b_rd_lane[g]),
      .b_addr (pb_addr),
      .b_wd   (pb_wdata[g*LANE_W +: LANE_W]),
      .b_rd   (pb_rdata[g*LANE_W +: LANE_W])
    );
  end

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_busy_o || pb_busy_o) |->
      (master_mode && !pa_ce_n && !pb_ce_n && pa_addr == pb_addr)); // R4

  AST_SLAVE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (!pa_busy_o && !pb_busy_o)); // R9

  AST_FLAGGED_NO_WRITE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (|a_wr_lane) |-> !(master_mode ? pa_busy_o : pa_busy_i)); // R8

  AST_FLAGGED_NO_WRITE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (|b_wr_lane) |-> !(master_mode ? pb_busy_o : pb_busy_i)); // R8

  AST_DESELECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pa_ce_n) |-> pa_rdata == '0) and ($past(pb_ce_n) |-> pb_rdata == '0)); // R3
endmodule

// File: tb/dpr_contend_top_tb.sv
module dpr_contend_top_tb;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic master_mode;
  logic pa_ce_n, pa_rw_n, pa_oe_n, pa_ub_n, pa_lb_n, pa_busy_i, pa_busy_o;
  logic pb_ce_n, pb_rw_n, pb_oe_n, pb_ub_n, pb_lb_n, pb_busy_i, pb_busy_o;
  logic [5:0]  pa_addr, pb_addr;
  logic [15:0] pa_wdata, pb_wdata, pa_rdata, pb_rdata;

  dpr_contend_top u_dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .pa_ce_n(pa_ce_n), .pa_rw_n(pa_rw_n), .pa_oe_n(pa_oe_n), .pa_ub_n(pa_ub_n),
    .pa_lb_n(pa_lb_n), .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_rdata(pa_rdata),
    .pa_busy_i(pa_busy_i), .pa_busy_o(pa_busy_o),
    .pb_ce_n(pb_ce_n), .pb_rw_n(pb_rw_n), .pb_oe_n(pb_oe_n), .pb_ub_n(pb_ub_n),
    .pb_lb_n(pb_lb_n), .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata),
    .pb_busy_i(pb_busy_i), .pb_busy_o(pb_busy_o)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] model [64];
  logic [15:0] exp_a_q[$], exp_b_q[$];
  string       tag_q[$];

  // shadow inputs, applied at the next falling edge
  logic [4:0]  sa, sb;   // {ce_n, rw_n, oe_n, ub_n, lb_n}
  logic [5:0]  sa_ad, sb_ad;
  logic [15:0] sa_d, sb_d;
  logic        s_master, s_bia, s_bib;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_a(input logic [4:0] c, input logic [5:0] ad, input logic [15:0] d);
    sa = c; sa_ad = ad; sa_d = d;
  endtask
  task automatic set_b(input logic [4:0] c, input logic [5:0] ad, input logic [15:0] d);
    sb = c; sb_ad = ad; sb_d = d;
  endtask

  function automatic logic [15:0] rd_exp(input logic [4:0] c, input logic [5:0] ad);
    logic [15:0] v = 16'h0000;
    if (!c[4] && c[3] && !c[2]) begin
      if (!c[1]) v[15:8] = model[ad][15:8];
      if (!c[0]) v[7:0]  = model[ad][7:0];
    end
    return v;
  endfunction

  task automatic mwrite(input logic [4:0] c, input logic [5:0] ad, input logic [15:0] d, input logic blk);
    if (!c[4] && !c[3] && !blk) begin
      if (!c[1]) model[ad][15:8] = d[15:8];
      if (!c[0]) model[ad][7:0]  = d[7:0];
    end
  endtask

  task automatic cyc(input logic eba, input logic ebb, input string tag);
    @(negedge clk);
    master_mode = s_master; pa_busy_i = s_bia; pb_busy_i = s_bib;
    {pa_ce_n, pa_rw_n, pa_oe_n, pa_ub_n, pa_lb_n} = sa; pa_addr = sa_ad; pa_wdata = sa_d;
    {pb_ce_n, pb_rw_n, pb_oe_n, pb_ub_n, pb_lb_n} = sb; pb_addr = sb_ad; pb_wdata = sb_d;
    #1;
    chk(pa_busy_o === eba && pb_busy_o === ebb, {tag, " busy"},
        {14'd0, pa_busy_o, pb_busy_o}, {14'd0, eba, ebb});
    exp_a_q.push_back(rd_exp(sa, sa_ad));
    exp_b_q.push_back(rd_exp(sb, sb_ad));
    tag_q.push_back(tag);
    mwrite(sa, sa_ad, sa_d, s_master ? eba : s_bia);
    mwrite(sb, sb_ad, sb_d, s_master ? ebb : s_bib);
  endtask

  localparam logic [4:0] OFF = 5'b11111;
  localparam logic [4:0] WR  = 5'b00100;  // both lanes
  localparam logic [4:0] WRU = 5'b00101;  // upper lane only
  localparam logic [4:0] WRL = 5'b00110;  // lower lane only
  localparam logic [4:0] RD  = 5'b01000;
  localparam logic [4:0] RDU = 5'b01001;
  localparam logic [4:0] RDL = 5'b01010;
  localparam logic [4:0] RDX = 5'b01100;  // output enable off

  // monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      if (exp_a_q.size() > 0) begin
        logic [15:0] ea, eb;
        string t;
        ea = exp_a_q.pop_front(); eb = exp_b_q.pop_front(); t = tag_q.pop_front();
        chk(pa_rdata === ea, {t, " rdata A"}, pa_rdata, ea);
        chk(pb_rdata === eb, {t, " rdata B"}, pb_rdata, eb);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'h0000;
    s_master = 1; s_bia = 0; s_bib = 0;
    set_a(OFF, 0, 0); set_b(OFF, 0, 0);
    master_mode = 1; pa_busy_i = 0; pb_busy_i = 0;
    {pa_ce_n, pa_rw_n, pa_oe_n, pa_ub_n, pa_lb_n} = OFF; pa_addr = 0; pa_wdata = 0;
    {pb_ce_n, pb_rw_n, pb_oe_n, pb_ub_n, pb_lb_n} = OFF; pb_addr = 0; pb_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(pa_rdata === 16'h0 && pb_rdata === 16'h0, "R11 reset rdata", pa_rdata | pb_rdata, 16'h0);
    chk(pa_busy_o === 1'b0 && pb_busy_o === 1'b0, "R11 reset busy", {14'd0, pa_busy_o, pb_busy_o}, 16'h0);
    @(negedge clk); rst_n = 1;
    cyc(0, 0, "R11 idle after reset");

    // R1/R4: writes at different addresses in the same cycle, no flag
    set_a(WR, 5, 16'h1234); set_b(WR, 9, 16'hABCD); cyc(0, 0, "R1 R4 dual write");
    set_a(WR, 20, 16'h1111); set_b(WR, 40, 16'h4040); cyc(0, 0, "R1 preload");
    set_a(RD, 5, 0); set_b(RD, 9, 0); cyc(0, 0, "R2 full read");
    // R1: lane writes
    set_a(WRU, 5, 16'hFF00); set_b(WRL, 9, 16'h0011); cyc(0, 0, "R1 lane write");
    set_a(RDL, 5, 0); set_b(RDU, 9, 0); cyc(0, 0, "R2 lane read");
    set_a(RD, 5, 0); set_b(RD, 9, 0); cyc(0, 0, "R1 lane kept");
    // R3: deselect and output enable off
    set_a(OFF | 5'b01000, 5, 0); set_b(RDX, 9, 0); cyc(0, 0, "R3 deselect");

    // R10 + R6: fresh collision, A writes, B reads the old word
    set_a(WR, 20, 16'h2222); set_b(RD, 20, 0); cyc(0, 1, "R10 R6 read old");
    set_a(OFF, 0, 0); set_b(RD, 20, 0); cyc(0, 0, "R10 new value");

    // R6/R8: both write the same word at once
    set_a(WR, 30, 16'hAAAA); set_b(WR, 30, 16'hBBBB); cyc(0, 1, "R6 R8 tie write");
    set_a(RD, 30, 0); set_b(RD, 30, 0); cyc(0, 1, "R7 tie held");
    set_a(OFF, 0, 0); set_b(OFF, 0, 0); cyc(0, 0, "R7 release");

    // R5/R8: B arrives first, A's write is dropped
    set_b(RD, 40, 0); cyc(0, 0, "R5 B first");
    set_a(WR, 40, 16'hCCCC); cyc(1, 0, "R5 R8 A flagged");
    set_a(OFF, 0, 0); cyc(0, 0, "R8 word kept");
    // R7: grant held, dropped on address change, regained by the holder
    set_a(RD, 40, 0); cyc(1, 0, "R5 A late");
    cyc(1, 0, "R7 held");
    set_a(RDX, 41, 0); cyc(0, 0, "R7 address differs");
    set_a(RD, 40, 0); cyc(1, 0, "R5 A returns");
    set_b(OFF, 0, 0); cyc(0, 0, "R7 chip enable off");
    set_a(OFF, 0, 0); cyc(0, 0, "idle");

    // R9: slave mode
    s_master = 0;
    set_a(WR, 51, 16'h5151); cyc(0, 0, "R9 slave write");
    s_bib = 1; set_a(OFF, 0, 0); set_b(WR, 51, 16'h9999); cyc(0, 0, "R9 flag input blocks");
    s_bib = 0; set_a(RD, 51, 0); set_b(RD, 51, 0); cyc(0, 0, "R9 no arbitration");
    s_bia = 1; set_a(WR, 52, 16'h7777); set_b(WR, 53, 16'h3535); cyc(0, 0, "R9 A blocked");
    s_bia = 0; set_a(RD, 53, 0); set_b(RD, 51, 0); cyc(0, 0, "R9 readback");
    set_a(OFF, 0, 0); set_b(OFF, 0, 0); cyc(0, 0, "idle");

    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule